// File: doc/BRIEF.md
# Multi-Word Security Policy Fetch Sequencer

This block loads one complete security policy for a memory-side cryptographic firewall out of a block RAM whose data port is one 32-bit word wide. The caller supplies only the index of the policy's first word and a one-cycle start pulse. The sequencer then reads that word and the words after it, one per cycle, from a synchronous RAM with a single cycle of read latency. It spreads the returned words over parallel outputs: the access and routing control bits, a 128-bit key, a log-timer value and a tag address.

When the last word has landed, the block raises a one-cycle valid strobe. The assembled fields stay stable until the next fetch starts overwriting them. A decoded routing mode is derived from the confidentiality and integrity bits, so that the cipher datapath can choose between encrypt-and-authenticate, authenticate-only and pass-through without decoding the bits itself.

Top module: `pfs_policy_fetch`

## Requirements
- R1: Reset behaviour. After reset, `busy_o`, `pol_valid_o` and `rd_en_o` are low, and the key, log-timer, tag and control outputs are all zero.
- R2: Read order. A start accepted from the idle state issues exactly six reads on consecutive cycles, to addresses base, base+1, ..., base+5. The addresses wrap modulo 2^ADDR_W.
- R3: Control word layout. The first word maps its fields as follows: bits [1:0] to `access_o`, [3:2] to `format_o`, bit 4 to `err_mode_o`, bit 5 to `conf_o` and bit 6 to `integ_o`. Bits [31:7] have no effect on any output.
- R4: Key order. Words two to five form `key_o`, most-significant word first. Word two becomes key[127:96] and word five becomes key[31:0].
- R5: Last word split. The sixth word gives `log_timer_o` from bits [31:16] and `tag_addr_o` from bits [15:0].
- R6: Valid strobe timing. `pol_valid_o` is high for exactly one cycle, seven clock edges after the edge that accepts start. All policy outputs then hold their values while no fetch runs.
- R7: Busy window. `busy_o` is high from the edge that accepts start until the edge that raises `pol_valid_o`, and is low in the valid cycle.
- R8: Start while busy. A start pulse arriving while `busy_o` is high is ignored. The running fetch keeps its base, issues no extra reads and produces no second valid strobe.
- R9: Mode decode. `mode_o` is 2'b11 when the confidentiality bit is set (whatever the integrity bit), 2'b01 for integrity only, and 2'b00 when both bits are clear. The value 2'b10 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a fetch; honoured only when idle |
| base_idx_i | input | ADDR_W | RAM index of the policy's first word |
| busy_o | output | 1 | Fetch in progress |
| rd_en_o | output | 1 | RAM read enable |
| rd_addr_o | output | ADDR_W | RAM read address |
| rd_data_i | input | 32 | RAM read data, one cycle after the address |
| pol_valid_o | output | 1 | One-cycle strobe: all fields assembled |
| access_o | output | 2 | Read/write permission field |
| format_o | output | 2 | Allowed data-width field |
| err_mode_o | output | 1 | Error-code response enable |
| conf_o | output | 1 | Confidentiality bit |
| integ_o | output | 1 | Integrity bit |
| mode_o | output | 2 | Decoded routing mode |
| key_o | output | 128 | Assembled key |
| log_timer_o | output | 16 | Log-timer value |
| tag_addr_o | output | 16 | Tag address |

## Verification
The bench builds the block with ADDR_W set to 6, so the RAM model holds only 64 words. A policy placed at index 61 therefore crosses the top of the address space, which exercises the wraparound of the incrementing read address. The key width stays at its default of four words, so the full six-word record and the seven-edge latency are covered exactly as specified. With the small RAM, the bench can also rewrite the control word between fetches and walk through all four combinations of the confidentiality and integrity bits.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
    localparam int WORD_W = 32;
    localparam int LOG_W  = 16;
    localparam int TAG_W  = 16;
    localparam int CTRL_W = 7;

    // Declared LSB-last so that a cast of word[6:0] puts access at [1:0].
    typedef struct packed {
        logic       integ;
        logic       conf;
        logic       err_mode;
        logic [1:0] fmt;
        logic [1:0] access;
    } ctrl_t;

    typedef enum logic [1:0] {
        MODE_PLAIN     = 2'b00,
        MODE_AUTH      = 2'b01,
        MODE_CIPH_AUTH = 2'b11
    } route_mode_e;
endpackage

// File: rtl/pfs_seq.sv
module pfs_seq #(
    parameter int ADDR_W = 10,
    parameter int NWORDS = 6,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_idx_i,
    output logic              busy_o,
    output logic              rd_en_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              cap_en_o,
    output logic [IDX_W-1:0]  cap_idx_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NWORDS - 1);

    typedef struct packed {
        logic              busy;
        logic              issuing;
        logic [IDX_W-1:0]  iss_idx;
        logic              cap_en;
        logic [IDX_W-1:0]  cap_idx;
        logic [ADDR_W-1:0] base;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        // capture trails issue by the RAM's one-cycle latency
        s_d.cap_en  = s_q.issuing;
        s_d.cap_idx = s_q.iss_idx;
        if (!s_q.busy && start_i) begin
            s_d.busy    = 1'b1;
            s_d.issuing = 1'b1;
            s_d.iss_idx = '0;
            s_d.base    = base_idx_i;
        end else if (s_q.issuing) begin
            if (s_q.iss_idx == LAST) s_d.issuing = 1'b0;
            else                     s_d.iss_idx = s_q.iss_idx + 1'b1;
        end
        if (s_q.cap_en && s_q.cap_idx == LAST) s_d.busy = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy_o    = s_q.busy;
    assign rd_en_o   = s_q.issuing;
    assign rd_addr_o = s_q.base + ADDR_W'(s_q.iss_idx);
    assign cap_en_o  = s_q.cap_en;
    assign cap_idx_o = s_q.cap_idx;
endmodule

// File: rtl/pfs_asm.sv
module pfs_asm
    import pfs_pkg::*;
#(
    parameter int KEY_WORDS = 4,
    parameter int IDX_W     = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cap_en_i,
    input  logic [IDX_W-1:0]           cap_idx_i,
    input  logic [WORD_W-1:0]          rd_data_i,
    output ctrl_t                      ctrl_o,
    output logic [KEY_WORDS*WORD_W-1:0] key_o,
    output logic [LOG_W-1:0]           log_o,
    output logic [TAG_W-1:0]           tag_o,
    output logic                       valid_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(KEY_WORDS + 1);

    typedef struct packed {
        ctrl_t                               ctrl;
        logic [KEY_WORDS-1:0][WORD_W-1:0]    key;
        logic [LOG_W-1:0]                    log;
        logic [TAG_W-1:0]                    tag;
        logic                                valid;
    } asm_t;

    asm_t a_d, a_q;

    always_comb begin
        a_d       = a_q;
        a_d.valid = 1'b0;
        if (cap_en_i) begin
            if (cap_idx_i == '0) a_d.ctrl = ctrl_t'(rd_data_i[CTRL_W-1:0]);
            for (int k = 0; k < KEY_WORDS; k++) begin
                // slot k+1 lands in the k-th most significant key word
                if (cap_idx_i == IDX_W'(k + 1)) a_d.key[KEY_WORDS-1-k] = rd_data_i;
            end
            if (cap_idx_i == LAST) begin
                a_d.log   = rd_data_i[WORD_W-1 -: LOG_W];
                a_d.tag   = rd_data_i[TAG_W-1:0];
                a_d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= a_d;
    end

    assign ctrl_o  = a_q.ctrl;
    assign key_o   = a_q.key;
    assign log_o   = a_q.log;
    assign tag_o   = a_q.tag;
    assign valid_o = a_q.valid;
endmodule

// File: rtl/pfs_mode_dec.sv
module pfs_mode_dec
    import pfs_pkg::*;
(
    input  logic conf_i,
    input  logic integ_i,
    output logic [1:0] mode_o
);
    route_mode_e mode;

    always_comb begin
        if (conf_i)       mode = MODE_CIPH_AUTH;
        else if (integ_i) mode = MODE_AUTH;
        else              mode = MODE_PLAIN;
    end

    assign mode_o = mode;
endmodule

// File: rtl/pfs_policy_fetch.sv
module pfs_policy_fetch
    import pfs_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int KEY_WORDS = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_i,
    input  logic [ADDR_W-1:0]           base_idx_i,
    output logic                        busy_o,
    output logic                        rd_en_o,
    output logic [ADDR_W-1:0]           rd_addr_o,
    input  logic [31:0]                 rd_data_i,
    output logic                        pol_valid_o,
    output logic [1:0]                  access_o,
    output logic [1:0]                  format_o,
    output logic                        err_mode_o,
    output logic                        conf_o,
    output logic                        integ_o,
    output logic [1:0]                  mode_o,
    output logic [KEY_WORDS*32-1:0]     key_o,
    output logic [15:0]                 log_timer_o,
    output logic [15:0]                 tag_addr_o
);
    localparam int NWORDS = KEY_WORDS + 2;
    localparam int IDX_W  = $clog2(NWORDS);

    logic             cap_en;
    logic [IDX_W-1:0] cap_idx;
    ctrl_t            ctrl;

    pfs_seq #(.ADDR_W(ADDR_W), .NWORDS(NWORDS), .IDX_W(IDX_W)) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .base_idx_i (base_idx_i),
        .busy_o     (busy_o),
        .rd_en_o    (rd_en_o),
        .rd_addr_o  (rd_addr_o),
        .cap_en_o   (cap_en),
        .cap_idx_o  (cap_idx)
    );

    pfs_asm #(.KEY_WORDS(KEY_WORDS), .IDX_W(IDX_W)) asm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_en_i  (cap_en),
        .cap_idx_i (cap_idx),
        .rd_data_i (rd_data_i),
        .ctrl_o    (ctrl),
        .key_o     (key_o),
        .log_o     (log_timer_o),
        .tag_o     (tag_addr_o),
        .valid_o   (pol_valid_o)
    );

    pfs_mode_dec dec_i (
        .conf_i  (ctrl.conf),
        .integ_i (ctrl.integ),
        .mode_o  (mode_o)
    );

    assign access_o   = ctrl.access;
    assign format_o   = ctrl.fmt;
    assign err_mode_o = ctrl.err_mode;
    assign conf_o     = ctrl.conf;
    assign integ_o    = ctrl.integ;
endmodule

// File: rtl/pfs_policy_fetch_chk.sv
module pfs_policy_fetch_chk #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_o,
    input logic              rd_en_o,
    input logic [ADDR_W-1:0] rd_addr_o,
    input logic              pol_valid_o,
    input logic [1:0]        mode_o
);
    // R2: back-to-back reads step the address by one
    a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_o && $past(rd_en_o)) |-> (rd_addr_o == $past(rd_addr_o) + 1'b1));

    // R2: no read outside a fetch
    a_r2_read_in_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o |-> busy_o);

    // R6: valid lasts one cycle
    a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pol_valid_o |=> !pol_valid_o);

    // R7: busy ends exactly when valid appears
    a_r7_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> pol_valid_o);

    // R7: busy is low in the valid cycle
    a_r7_busy_low_at_valid: assert property (@(posedge clk) disable iff (!rst_n)
        pol_valid_o |-> !busy_o);

    // R9: reserved mode code never produced
    a_r9_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o != 2'b10);
endmodule

bind pfs_policy_fetch pfs_policy_fetch_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy_o      (busy_o),
    .rd_en_o     (rd_en_o),
    .rd_addr_o   (rd_addr_o),
    .pol_valid_o (pol_valid_o),
    .mode_o      (mode_o)
);

// File: tb/pfs_policy_fetch_tb_top.sv
`timescale 1ns/1ps
module pfs_policy_fetch_tb_top;
    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] base_idx = '0;
    logic          busy, rd_en, valid;
    logic [AW-1:0] rd_addr;
    logic [31:0]   rd_data = '0;
    logic [1:0]    access, fmt, mode;
    logic          err_mode, conf, integ;
    logic [127:0]  key;
    logic [15:0]   log_timer, tag_addr;

    logic [31:0]   mem [DEPTH];
    logic [AW-1:0] rd_log [512];
    int            rd_cnt = 0;
    int            n_chk = 0;
    int            n_bad = 0;
    int            cyc = 0;

    always #5 clk = ~clk;

    pfs_policy_fetch #(.ADDR_W(AW), .KEY_WORDS(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .base_idx_i(base_idx),
        .busy_o(busy), .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
        .pol_valid_o(valid), .access_o(access), .format_o(fmt),
        .err_mode_o(err_mode), .conf_o(conf), .integ_o(integ), .mode_o(mode),
        .key_o(key), .log_timer_o(log_timer), .tag_addr_o(tag_addr)
    );

    // RAM model with one cycle of read latency, plus a read recorder
    always @(posedge clk) begin
        if (rd_en) begin
            rd_data <= mem[rd_addr];
            if (rd_cnt < 512) rd_log[rd_cnt] <= rd_addr;
            rd_cnt <= rd_cnt + 1;
        end
    end

    task automatic summary_and_end();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_chk = n_chk + 1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual=hung expected=done");
            summary_and_end();
        end
    end

    task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_mode(logic [31:0] w0);
        if (w0[5])      return 2'b11;
        else if (w0[6]) return 2'b01;
        return 2'b00;
    endfunction

    // Run one fetch from base b; optionally pulse a second start mid-fetch.
    task automatic do_fetch(logic [AW-1:0] b, bit inject, logic [AW-1:0] alt, string name);
        int r0, cycles;
        logic [31:0] w [6];
        for (int j = 0; j < 6; j++) w[j] = mem[AW'(b + j)];
        @(negedge clk);
        r0 = rd_cnt;
        start = 1'b1;
        base_idx = b;
        @(negedge clk);
        start = 1'b0;
        check({name, " R7 busy after start"}, busy, 1);
        cycles = 0;
        while (!valid && cycles < 20) begin
            if (inject && cycles == 2) begin
                start = 1'b1;
                base_idx = alt;
            end
            @(negedge clk);
            start = 1'b0;
            cycles++;
            if (!valid && busy !== 1'b1)
                check({name, " R7 busy held"}, busy, 1);
        end
        check({name, " R6 latency"}, cycles, 7);
        check({name, " R7 busy low at valid"}, busy, 0);
        check({name, " R2 read count"}, rd_cnt - r0, 6);
        for (int j = 0; j < 6; j++)
            if (rd_log[r0 + j] !== AW'(b + j))
                check({name, " R2 read addr"}, rd_log[r0 + j], AW'(b + j));
        check({name, " R3 ctrl"}, {integ, conf, err_mode, fmt, access}, w[0][6:0]);
        check({name, " R4 key"}, key, {w[1], w[2], w[3], w[4]});
        check({name, " R5 log/tag"}, {log_timer, tag_addr}, w[5]);
        check({name, " R9 mode"}, mode, exp_mode(w[0]));
        @(negedge clk);
        check({name, " R6 pulse"}, valid, 0);
    endtask

    task automatic test_reset();
        check("R1 busy", busy, 0);
        check("R1 valid", valid, 0);
        check("R1 rd_en", rd_en, 0);
        check("R1 key", key, 0);
        check("R1 fields", {log_timer, tag_addr, access, fmt, err_mode, conf, integ}, 0);
    endtask

    task automatic test_modes();
        // R3: upper bits of word 0 set to junk; R9 all four bit pairs
        mem[8]  = 32'hFFFF_FF80 | 32'h0000_0060 | 32'h0000_001B;
        do_fetch(6'd8, 0, '0, "ci");
        mem[8]  = 32'hA5A5_A580 | 32'h0000_0040 | 32'h0000_0006;
        do_fetch(6'd8, 0, '0, "auth");
        mem[8]  = 32'h1234_5600 | 32'h0000_0011;
        do_fetch(6'd8, 0, '0, "plain");
        mem[8]  = 32'h0000_0020;
        do_fetch(6'd8, 0, '0, "conf_only");
    endtask

    task automatic test_wrap();
        do_fetch(6'd61, 0, '0, "wrap R2");
    endtask

    task automatic test_busy_start();
        int r1;
        do_fetch(6'd20, 1, 6'd40, "R8 ignore");
        r1 = rd_cnt;
        repeat (10) begin
            @(negedge clk);
            if (valid) check("R8 no second valid", valid, 0);
        end
        check("R8 no extra reads", rd_cnt - r1, 0);
    endtask

    task automatic test_hold();
        logic [127:0] k;
        logic [31:0]  lt;
        do_fetch(6'd30, 0, '0, "hold");
        k = key;
        lt = {log_timer, tag_addr};
        repeat (5) @(negedge clk);
        check("R6 key held", key, k);
        check("R6 log/tag held", {log_timer, tag_addr}, lt);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = 32'h9E37_79B9 * (i + 1) ^ 32'h5A5A_0000;
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_modes();
        test_wrap();
        test_busy_start();
        test_hold();
        do_fetch(6'd0, 0, '0, "base0");
        do_fetch(6'd1, 0, '0, "back2back");
        summary_and_end();
    end
endmodule